// File: doc/BRIEF.md
# Operand Bus Master Interface

This block lets a processor core become master of a shared operand bus and run transfers on it. When the core raises a transfer request, the block asks an external arbiter for the bus. It takes ownership only when the arbiter grants the bus and no other master reports itself busy. While it holds the bus it announces ownership on its own acknowledge line. It then runs read or write cycles, each qualified as a memory or I/O access. Each cycle is stretched until the addressed device acknowledges the transfer.

Every bus pin is modelled as a value plus a separate output enable, which stands for a three-state pin. Outside ownership, every enable except the bus request is low. The bus request is driven at all times except in test mode. The core holds its start line and transfer attributes until it sees a one-clock done pulse. If it keeps start high after done with new attributes, a further cycle runs without giving up the bus.

Top module: `opbus_master`

## Requirements
- R1: After reset, bus_req_n is 1 and driven, no other bus enable is active, and core_done is 0.
- R2: With the block idle, bus_req_n goes low one clock after core_start is sampled high. It stays low for as long as grant_n is 1.
- R3: While busy_n is 0, the block stays in the request phase even when grant_n is 0. own_ack_oe stays 0.
- R4: On the first clock where grant_n is 0 and busy_n is 1 during the request phase, ownership begins at the next edge. From then on own_ack_oe is 1, own_ack_n is 0 and bus_req_n is 1.
- R5: Outside ownership, own_ack_oe, addr_oe, mem_io_oe, rd_wr_oe and data_oe are all 0.
- R6: During a cycle, addr_o shows the core address and mem_io is 1 for memory and 0 for I/O. rd_wr is 1 for a read and 0 for a write. data_oe is 1 with data_o equal to the write data only in a write cycle.
- R7: A cycle continues while xfer_ack_n is sampled 1. core_done pulses for exactly one clock, one clock after the edge that samples xfer_ack_n at 0.
- R8: With xfer_ack_n held at 0, the cycle lasts one clock. core_done follows two clocks after the edge at which an owning block sees core_start.
- R9: In a read cycle, core_rdata takes the value on data_i at the acknowledging edge and holds it afterwards.
- R10: While test_n is 0, bus_req_oe is 0. When test_n is 1, bus_req_oe is 1.
- R11: If core_start is low after the done clock, the block keeps the bus for one more clock, then leaves ownership and returns to idle.
- R12: If core_start stays high after done, the next cycle starts without a new bus request, and ownership is kept throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_n | input | 1 | Test mode, active low; floats the bus request |
| core_start | input | 1 | Core transfer request, held until done |
| core_write | input | 1 | 1 = write, 0 = read |
| core_mem | input | 1 | 1 = memory space, 0 = I/O space |
| core_addr | input | ADDR_W | Transfer address |
| core_wdata | input | DATA_W | Write data |
| core_done | output | 1 | One-clock completion pulse |
| core_rdata | output | DATA_W | Captured read data |
| bus_req_n | output | 1 | Bus request, active low |
| bus_req_oe | output | 1 | Enable for bus_req_n |
| grant_n | input | 1 | Bus grant, active low |
| busy_n | input | 1 | Other master busy, active low |
| own_ack_n | output | 1 | Ownership acknowledge, active low |
| own_ack_oe | output | 1 | Enable for own_ack_n |
| xfer_ack_n | input | 1 | Transfer acknowledge, active low |
| mem_io | output | 1 | Memory (1) or I/O (0) qualifier |
| mem_io_oe | output | 1 | Enable for mem_io |
| rd_wr | output | 1 | Read (1) or write (0) |
| rd_wr_oe | output | 1 | Enable for rd_wr |
| addr_o | output | ADDR_W | Bus address |
| addr_oe | output | 1 | Enable for addr_o |
| data_o | output | DATA_W | Bus write data |
| data_oe | output | 1 | Enable for data_o |
| data_i | input | DATA_W | Bus read data |

## Verification
The assertions assume that every input is synchronous to clk and settles well before each rising edge. They also assume that the core keeps core_start and its attributes steady from the request until the done pulse. The bench changes inputs only on falling edges and reads outputs there. It changes the attributes only in the done clock, as an immediate follow-on request does. Grant, busy and transfer acknowledge are varied freely, including a busy held low with grant present and acknowledges delayed by several clocks.

// File: rtl/opbus_pkg.sv
package opbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_OWN  = 3'd2,
        ST_CYC  = 3'd3,
        ST_REL  = 3'd4
    } own_st_e;
endpackage

// File: rtl/opbus_own_fsm.sv
module opbus_own_fsm
    import opbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    grant_n_i,
    input  logic    busy_n_i,
    input  logic    xfer_ack_n_i,
    input  logic    done_i,
    output own_st_e state_o,
    output logic    launch_o
);
    typedef struct packed {
        own_st_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        launch_o = 1'b0;
        case (r_q.st)
            ST_IDLE: if (start_i) r_d.st = ST_REQ;
            ST_REQ:  if (!grant_n_i && busy_n_i) r_d.st = ST_OWN;
            ST_OWN: begin
                if (done_i) begin
                    r_d.st = ST_OWN;
                end else if (start_i) begin
                    r_d.st   = ST_CYC;
                    launch_o = 1'b1;
                end else begin
                    r_d.st = ST_REL;
                end
            end
            ST_CYC:  if (!xfer_ack_n_i) r_d.st = ST_OWN;
            ST_REL:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE};
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;

    // R3: a busy master keeps the block waiting
    p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REQ && !busy_n_i) |=> (r_q.st == ST_REQ));

    // R2: no grant, no ownership
    p_wait_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REQ && grant_n_i) |=> (r_q.st == ST_REQ));

    // R7: the cycle is stretched until acknowledged
    p_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CYC && xfer_ack_n_i) |=> (r_q.st == ST_CYC));
endmodule

// File: rtl/opbus_cycle_unit.sv
module opbus_cycle_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              in_cyc_i,
    input  logic              xfer_ack_n_i,
    input  logic              write_i,
    input  logic              mem_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              lat_write_o,
    output logic              lat_mem_o,
    output logic [ADDR_W-1:0] lat_addr_o,
    output logic [DATA_W-1:0] lat_wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    typedef struct packed {
        logic              write;
        logic              mem;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } cyc_regs_t;

    cyc_regs_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (launch_i) begin
            c_d.write = write_i;
            c_d.mem   = mem_i;
            c_d.addr  = addr_i;
            c_d.wdata = wdata_i;
        end
        if (in_cyc_i && !xfer_ack_n_i) begin
            c_d.done = 1'b1;
            if (!c_q.write) c_d.rdata = rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign lat_write_o = c_q.write;
    assign lat_mem_o   = c_q.mem;
    assign lat_addr_o  = c_q.addr;
    assign lat_wdata_o = c_q.wdata;
    assign rdata_o     = c_q.rdata;
    assign done_o      = c_q.done;

    // R7: done follows an acknowledged cycle edge
    p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |-> $past(in_cyc_i && !xfer_ack_n_i));

    // R7: done is a single-clock pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done);

    // R6: attributes stay fixed through a stretched cycle
    p_attr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cyc_i && $past(in_cyc_i)) |-> ($stable(c_q.addr) && $stable(c_q.write) && $stable(c_q.mem)));
endmodule

// File: rtl/opbus_pin_drive.sv
module opbus_pin_drive
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  own_st_e           state_i,
    input  logic              test_n_i,
    input  logic              lat_write_i,
    input  logic              lat_mem_i,
    input  logic [ADDR_W-1:0] lat_addr_i,
    input  logic [DATA_W-1:0] lat_wdata_i,
    output logic              bus_req_n_o,
    output logic              bus_req_oe_o,
    output logic              own_ack_n_o,
    output logic              own_ack_oe_o,
    output logic              mem_io_o,
    output logic              mem_io_oe_o,
    output logic              rd_wr_o,
    output logic              rd_wr_oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    logic owning;
    logic cycling;

    always_comb begin
        owning        = (state_i == ST_OWN) || (state_i == ST_CYC);
        cycling       = (state_i == ST_CYC);
        bus_req_n_o   = (state_i != ST_REQ);
        bus_req_oe_o  = test_n_i;
        own_ack_n_o   = !owning;
        own_ack_oe_o  = owning;
        mem_io_o      = lat_mem_i;
        mem_io_oe_o   = owning;
        rd_wr_o       = !lat_write_i;
        rd_wr_oe_o    = owning;
        addr_o        = lat_addr_i;
        addr_oe_o     = owning;
        data_o        = lat_wdata_i;
        data_oe_o     = cycling && lat_write_i;
    end

    // R4: request is released once ownership is announced
    p_req_off_owning_r4: assert property (@(posedge clk) disable iff (!rst_n)
        own_ack_oe_o |-> bus_req_n_o);

    // R6: write data only leaves the block in a write cycle
    p_data_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (!rd_wr_o && rd_wr_oe_o));
endmodule

// File: rtl/opbus_master.sv
module opbus_master
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_n,
    input  logic              core_start,
    input  logic              core_write,
    input  logic              core_mem,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    output logic              bus_req_n,
    output logic              bus_req_oe,
    input  logic              grant_n,
    input  logic              busy_n,
    output logic              own_ack_n,
    output logic              own_ack_oe,
    input  logic              xfer_ack_n,
    output logic              mem_io,
    output logic              mem_io_oe,
    output logic              rd_wr,
    output logic              rd_wr_oe,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_i
);
    own_st_e           state;
    logic              launch;
    logic              in_cyc;
    logic              lat_write;
    logic              lat_mem;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    assign in_cyc = (state == ST_CYC);

    opbus_own_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (core_start),
        .grant_n_i    (grant_n),
        .busy_n_i     (busy_n),
        .xfer_ack_n_i (xfer_ack_n),
        .done_i       (core_done),
        .state_o      (state),
        .launch_o     (launch)
    );

    opbus_cycle_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cyc (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .in_cyc_i     (in_cyc),
        .xfer_ack_n_i (xfer_ack_n),
        .write_i      (core_write),
        .mem_i        (core_mem),
        .addr_i       (core_addr),
        .wdata_i      (core_wdata),
        .rdata_i      (data_i),
        .lat_write_o  (lat_write),
        .lat_mem_o    (lat_mem),
        .lat_addr_o   (lat_addr),
        .lat_wdata_o  (lat_wdata),
        .rdata_o      (core_rdata),
        .done_o       (core_done)
    );

    opbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (state),
        .test_n_i     (test_n),
        .lat_write_i  (lat_write),
        .lat_mem_i    (lat_mem),
        .lat_addr_i   (lat_addr),
        .lat_wdata_i  (lat_wdata),
        .bus_req_n_o  (bus_req_n),
        .bus_req_oe_o (bus_req_oe),
        .own_ack_n_o  (own_ack_n),
        .own_ack_oe_o (own_ack_oe),
        .mem_io_o     (mem_io),
        .mem_io_oe_o  (mem_io_oe),
        .rd_wr_o      (rd_wr),
        .rd_wr_oe_o   (rd_wr_oe),
        .addr_o       (addr_o),
        .addr_oe_o    (addr_oe),
        .data_o       (data_o),
        .data_oe_o    (data_oe)
    );

    // R4: ownership starts only after grant with no busy master
    p_owner_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_ack_oe) |-> $past(!grant_n && busy_n));

    // R5: nothing but the request is driven without ownership
    p_hiz_unowned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !own_ack_oe |-> !(addr_oe || mem_io_oe || rd_wr_oe || data_oe));
endmodule

// File: tb/opbus_master_tb.sv
module opbus_master_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NV = 6;

    typedef struct packed {
        logic          wr;
        logic          mem;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        logic [3:0]    wt;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h1234, 16'h0000, 16'hBEEF, 4'd0},
        '{1'b1, 1'b1, 16'h2000, 16'hA5A5, 16'h0000, 4'd0},
        '{1'b0, 1'b0, 16'h00F0, 16'h0000, 16'h5A5A, 4'd3},
        '{1'b1, 1'b0, 16'h0F0F, 16'h1357, 16'h0000, 4'd2},
        '{1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'h0001, 4'd1},
        '{1'b1, 1'b1, 16'h8001, 16'hFFFF, 16'h0000, 4'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_n = 1'b1;
    logic core_start = 1'b0, core_write = 1'b0, core_mem = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0, data_i = '0;
    logic grant_n = 1'b1, busy_n = 1'b1, xfer_ack_n = 1'b1;
    logic core_done, bus_req_n, bus_req_oe, own_ack_n, own_ack_oe;
    logic mem_io, mem_io_oe, rd_wr, rd_wr_oe, addr_oe, data_oe;
    logic [DW-1:0] core_rdata, data_o;
    logic [AW-1:0] addr_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    opbus_master #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .test_n(test_n),
        .core_start(core_start), .core_write(core_write), .core_mem(core_mem),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_done(core_done), .core_rdata(core_rdata),
        .bus_req_n(bus_req_n), .bus_req_oe(bus_req_oe),
        .grant_n(grant_n), .busy_n(busy_n),
        .own_ack_n(own_ack_n), .own_ack_oe(own_ack_oe),
        .xfer_ack_n(xfer_ack_n),
        .mem_io(mem_io), .mem_io_oe(mem_io_oe),
        .rd_wr(rd_wr), .rd_wr_oe(rd_wr_oe),
        .addr_o(addr_o), .addr_oe(addr_oe),
        .data_o(data_o), .data_oe(data_oe), .data_i(data_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    function automatic logic [31:0] any_oe();
        return {27'd0, own_ack_oe, addr_oe, mem_io_oe, rd_wr_oe, data_oe};
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        nxt(); nxt();
        rst_n = 1'b1;
        nxt();
        // R1 reset state
        chk("R1 req_n", bus_req_n, 1);
        chk("R1 req_oe", bus_req_oe, 1);
        chk("R1 oe", any_oe(), 0);
        chk("R1 done", core_done, 0);

        // vector table walk, grant present and no busy master
        grant_n = 1'b0;
        busy_n  = 1'b1;
        for (int v = 0; v < NV; v++) begin
            core_start = 1'b1;
            core_write = VECS[v].wr;
            core_mem   = VECS[v].mem;
            core_addr  = VECS[v].addr;
            core_wdata = VECS[v].wd;
            xfer_ack_n = 1'b1;
            nxt();
            chk("R2 req low", bus_req_n, 0);
            chk("R5 no own yet", own_ack_oe, 0);
            nxt();
            chk("R4 own_ack_oe", own_ack_oe, 1);
            chk("R4 own_ack_n", own_ack_n, 0);
            chk("R4 req dropped", bus_req_n, 1);
            xfer_ack_n = (VECS[v].wt == 0) ? 1'b0 : 1'b1;
            data_i     = VECS[v].rd;
            nxt();
            chk("R6 addr", addr_o, VECS[v].addr);
            chk("R6 addr_oe", addr_oe, 1);
            chk("R6 mem_io", mem_io, VECS[v].mem);
            chk("R6 rd_wr", rd_wr, !VECS[v].wr);
            chk("R6 data_oe", data_oe, VECS[v].wr);
            if (VECS[v].wr) chk("R6 data_o", data_o, VECS[v].wd);
            if (VECS[v].wt == 0) chk("R8 no done yet", core_done, 0);
            for (int i = 0; i < int'(VECS[v].wt); i++) begin
                nxt();
                chk("R7 stretched", core_done, 0);
                chk("R7 still cycling", addr_oe, 1);
                if (i == int'(VECS[v].wt) - 1) xfer_ack_n = 1'b0;
            end
            nxt();
            chk((VECS[v].wt == 0) ? "R8 done" : "R7 done", core_done, 1);
            if (!VECS[v].wr) chk("R9 rdata", core_rdata, VECS[v].rd);
            core_start = 1'b0;
            xfer_ack_n = 1'b1;
            data_i     = 16'h0BAD;
            nxt();
            chk("R7 single pulse", core_done, 0);
            chk("R11 still owned", own_ack_oe, 1);
            if (!VECS[v].wr) chk("R9 rdata held", core_rdata, VECS[v].rd);
            nxt();
            chk("R11 released", own_ack_oe, 0);
            chk("R5 all off", any_oe(), 0);
            nxt();
            chk("R11 idle", bus_req_n, 1);
        end

        // busy master blocks ownership despite grant
        grant_n = 1'b0;
        busy_n  = 1'b0;
        core_start = 1'b1;
        core_write = 1'b0;
        for (int i = 0; i < 4; i++) begin
            nxt();
            chk("R3 req held", bus_req_n, 0);
            chk("R3 no own", own_ack_oe, 0);
        end
        busy_n = 1'b1;
        nxt();
        chk("R4 own after busy", own_ack_oe, 1);
        core_start = 1'b0;
        nxt();
        chk("R11 release no work", own_ack_oe, 0);
        nxt();

        // no grant keeps request pending
        grant_n = 1'b1;
        core_start = 1'b1;
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R2 req held", bus_req_n, 0);
            chk("R2 no own", own_ack_oe, 0);
        end
        grant_n = 1'b0;
        nxt();
        chk("R4 own after grant", own_ack_oe, 1);
        core_start = 1'b0;
        nxt(); nxt();

        // test mode floats the request
        test_n = 1'b0;
        nxt();
        chk("R10 req float", bus_req_oe, 0);
        test_n = 1'b1;
        nxt();
        chk("R10 req driven", bus_req_oe, 1);

        // back-to-back cycles under one ownership
        core_start = 1'b1;
        core_write = 1'b1;
        core_mem   = 1'b1;
        core_addr  = 16'h0400;
        core_wdata = 16'hC0DE;
        xfer_ack_n = 1'b0;
        nxt(); nxt(); nxt();
        nxt();
        chk("R8 first done", core_done, 1);
        core_write = 1'b0;
        core_mem   = 1'b0;
        core_addr  = 16'h0055;
        nxt();
        chk("R12 kept bus", own_ack_oe, 1);
        chk("R12 no new req", bus_req_n, 1);
        data_i = 16'h7E57;
        nxt();
        chk("R12 second addr", addr_o, 16'h0055);
        chk("R12 second read", rd_wr, 1);
        chk("R12 io", mem_io, 0);
        chk("R12 req quiet", bus_req_n, 1);
        nxt();
        chk("R12 second done", core_done, 1);
        chk("R9 second rdata", core_rdata, 16'h7E57);
        core_start = 1'b0;
        nxt(); nxt();
        chk("R5 final off", any_oe(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule